// File: doc/BRIEF.md
# Tearing-Effect Synchronized Burst Controller

This controller runs one burst of display payload on a single virtual channel of a serial display link. The burst starts in one of two ways. In the first, software sets a one-shot arm bit and the next tearing-effect trigger pulse starts the burst. In the second, software issues a start strobe directly. A 16-bit byte budget is loaded while the block is idle. During the burst the block breaks the budget into long packets. For each packet it raises a header request that carries the virtual channel number and that packet's size. Every packet uses the programmed word count except the last one, which carries whatever is left of the budget. The downstream packetizer acknowledges each header and then accepts payload bytes one at a time. The budget counts down live with each accepted byte, and the block pulses `done` when the budget reaches zero.

Payload can come from DMA or from the video port. With DMA as the source, one of four request lines is raised for the whole burst, and a 3-bit selector picks which line. With the video port as the source, no request line is raised. The video port needs a line buffer to hold its data, so the block refuses to start in that mode when the configured line buffer size is zero. The block also refuses to arm or start in two other cases. One is when the transmit FIFO still holds data for this channel. The other is when the word count is zero. Each refusal raises a sticky error flag, and the flag clears on the next accepted arm or start.

Top module: `te_burst_ctrl`

## Requirements
- R1: `arm_set` while idle, with a legal configuration and the FIFO empty, sets `armed`. A later `te_trig` pulse while idle and armed starts the burst, and `busy` is high from the next cycle. `armed` clears in the same cycle that `done` pulses.
- R2: `sw_start` while idle starts the burst whether or not the block is armed.
- R3: A `te_trig` pulse while not armed, or any `te_trig`/`sw_start` pulse while busy, has no effect. A budget write while busy is also ignored, so `remaining` keeps counting the current burst.
- R4: `remaining` decreases by exactly one for each cycle with `byte_take` high during a payload phase. A header acknowledge does not change it.
- R5: Each header request (`pkt_req` high until `pkt_ack`) carries `pkt_vc` = `cfg_vc` and `pkt_wc` = min(`cfg_wc`, `remaining`). This gives full-size packets followed by a shorter final packet.
- R6: On the last payload byte, `remaining` becomes 0, `busy` drops and `done` is high for exactly one cycle. The block does not restart by itself.
- R7: In DMA mode (`cfg_src_video`=0), while busy, `dma_req[cfg_dma_sel]` is high and every other bit is low. A selector value of 4 to 7 drives no bit. All bits are low while idle.
- R8: In video mode (`cfg_src_video`=1), `dma_req` stays 0. If `cfg_linebuf`=0 in video mode, a start or arm attempt is refused and `cfg_err` is set to 1.
- R9: A start or arm attempt while `txfifo_nempty`=1 is refused, leaves `armed` unchanged and sets `fifo_err` to 1.
- R10: With `cfg_wc`=0, a start attempt is refused, the block stays idle and `cfg_err` is set to 1. The next accepted start clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_budget | input | 16 | Byte budget value to load |
| cfg_budget_we | input | 1 | Load strobe for the budget (honoured only while idle) |
| cfg_wc | input | 16 | Packet word count in bytes |
| cfg_vc | input | 2 | Virtual channel number |
| cfg_src_video | input | 1 | 1 = video port source, 0 = DMA source |
| cfg_dma_sel | input | 3 | DMA request line selector (0..3 valid) |
| cfg_linebuf | input | 2 | Line buffer size setting; 0 = none |
| arm_set | input | 1 | Request to set the one-shot arm bit |
| sw_start | input | 1 | Software start strobe |
| te_trig | input | 1 | Tearing-effect trigger pulse |
| txfifo_nempty | input | 1 | Transmit FIFO holds data for this channel |
| pkt_ack | input | 1 | Packetizer accepted the header request |
| byte_take | input | 1 | Packetizer accepted one payload byte |
| pkt_req | output | 1 | Header request pending |
| pkt_vc | output | 2 | Virtual channel of the requested packet |
| pkt_wc | output | 16 | Byte size of the requested packet |
| dma_req | output | 4 | DMA request lines |
| busy | output | 1 | Burst in progress |
| armed | output | 1 | Automatic arm bit |
| remaining | output | 16 | Live byte budget |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last attempt refused for configuration |
| fifo_err | output | 1 | Last attempt refused for pending FIFO data |

## Verification
The hardest case to reach is a burst of several packets whose final packet is shorter than the rest. It has to be driven while stray trigger and start pulses and a budget rewrite arrive in the middle of the burst. The bench plays the packetizer: it acknowledges each header, takes bytes one per cycle, and predicts every header size and every budget value from the starting budget. It injects the stray pulses and the rewrite partway through a packet, then confirms that the byte count keeps moving as before and that `busy` stays low after `done`.

// File: rtl/te_burst_ctrl.sv
module te_burst_ctrl #(
  parameter int CNT_W = 16,
  parameter int VC_W  = 2,
  parameter int SEL_W = 3,
  parameter int NDMA  = 4,
  parameter int LB_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_budget,
  input  logic             cfg_budget_we,
  input  logic [CNT_W-1:0] cfg_wc,
  input  logic [VC_W-1:0]  cfg_vc,
  input  logic             cfg_src_video,
  input  logic [SEL_W-1:0] cfg_dma_sel,
  input  logic [LB_W-1:0]  cfg_linebuf,
  input  logic             arm_set,
  input  logic             sw_start,
  input  logic             te_trig,
  input  logic             txfifo_nempty,
  input  logic             pkt_ack,
  input  logic             byte_take,
  output logic             pkt_req,
  output logic [VC_W-1:0]  pkt_vc,
  output logic [CNT_W-1:0] pkt_wc,
  output logic [NDMA-1:0]  dma_req,
  output logic             busy,
  output logic             armed,
  output logic [CNT_W-1:0] remaining,
  output logic             done,
  output logic             cfg_err,
  output logic             fifo_err
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} st_t;

  st_t              st;
  logic [CNT_W-1:0] rem, pkt_left;
  logic             arm_q, done_q, cerr_q, ferr_q;

  wire idle     = (st == S_IDLE);
  wire cfg_bad  = (cfg_wc == '0) || (cfg_src_video && cfg_linebuf == '0);
  wire attempt  = idle && (arm_set || sw_start || (arm_q && te_trig));
  wire go       = idle && (sw_start || (arm_q && te_trig)) && !cfg_bad && !txfifo_nempty && rem != '0;
  wire arm_ok   = idle && arm_set && !cfg_bad && !txfifo_nempty;
  wire [CNT_W-1:0] pkt_size = (rem < cfg_wc) ? rem : cfg_wc;
  wire last_b   = (st == S_PAY) && byte_take && pkt_left == 1;
  wire finish   = last_b && rem == 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      pkt_left <= '0;
      arm_q    <= 1'b0;
      done_q   <= 1'b0;
      cerr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (attempt) begin
        cerr_q <= cfg_bad;
        ferr_q <= txfifo_nempty;
      end
      if (arm_ok) arm_q <= 1'b1;
      else if (finish) arm_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cfg_budget_we) rem <= cfg_budget;
          if (go) st <= S_HDR;
        end
        S_HDR: if (pkt_ack) begin
          pkt_left <= pkt_size;
          st       <= S_PAY;
        end
        S_PAY: if (byte_take) begin
          rem      <= rem - 1'b1;
          pkt_left <= pkt_left - 1'b1;
          if (pkt_left == 1) st <= (rem == 1) ? S_IDLE : S_HDR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NDMA; i++) begin : g_dma
    assign dma_req[i] = !idle && !cfg_src_video && cfg_dma_sel == SEL_W'(i);
  end

  assign pkt_req   = (st == S_HDR);
  assign pkt_vc    = cfg_vc;
  assign pkt_wc    = pkt_size;
  assign busy      = !idle;
  assign armed     = arm_q;
  assign remaining = rem;
  assign done      = done_q;
  assign cfg_err   = cerr_q;
  assign fifo_err  = ferr_q;

  AST_IDLE_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dma_req == '0); // R7
  AST_DMA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_req)); // R7
  AST_VIDEO_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_src_video |-> dma_req == '0); // R8
  AST_BYTE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY && byte_take) |=> remaining == $past(remaining) - 1'b1); // R4
  AST_HDR_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |=> $stable(remaining)); // R4
  AST_HDR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |-> (pkt_wc != '0 && pkt_wc <= cfg_wc)); // R5
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remaining == '0 && !busy && !armed)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_WC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wc == '0 && !busy) |=> !busy); // R10

endmodule

// File: tb/test_te_burst_ctrl.sv
`timescale 1ns/1ps
module test_te_burst_ctrl;
  logic clk = 0, rst_n = 0;
  logic [15:0] cfg_budget = 0, cfg_wc = 0;
  logic cfg_budget_we = 0, cfg_src_video = 0;
  logic [1:0] cfg_vc = 0, cfg_linebuf = 0;
  logic [2:0] cfg_dma_sel = 0;
  logic arm_set = 0, sw_start = 0, te_trig = 0, txfifo_nempty = 0, pkt_ack = 0, byte_take = 0;
  logic pkt_req, busy, armed, done, cfg_err, fifo_err;
  logic [1:0] pkt_vc;
  logic [15:0] pkt_wc, remaining;
  logic [3:0] dma_req;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  te_burst_ctrl i_te_burst_ctrl (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic load(input int budget, input int wc);
    cfg_budget = 16'(budget); cfg_wc = 16'(wc); cfg_budget_we = 1;
    tick(); cfg_budget_we = 0;
  endtask

  // Acts as the packetizer; optional stray pulses mid-burst (R3)
  task automatic drain(input int budget, input int wc, input int exp_dma, input bit stray);
    int rem = budget;
    int n = 0;
    while (rem > 0) begin
      int sz = (rem < wc) ? rem : wc;
      chk("R5 pkt_req", int'(pkt_req), 1);
      chk("R5 pkt_wc", int'(pkt_wc), sz);
      chk("R5 pkt_vc", int'(pkt_vc), int'(cfg_vc));
      chk("R7 dma_req", int'(dma_req), exp_dma);
      pkt_ack = 1; tick(); pkt_ack = 0;
      chk("R4 hdr no dec", int'(remaining), rem);
      for (int b = 0; b < sz; b++) begin
        byte_take = 1;
        if (stray && n == 1) begin
          te_trig = 1; sw_start = 1; cfg_budget = 16'd999; cfg_budget_we = 1;
        end
        tick();
        te_trig = 0; sw_start = 0; cfg_budget_we = 0;
        rem--; n++;
        chk("R4 remaining", int'(remaining), rem);
        if (rem == 0) begin
          chk("R6 done", int'(done), 1);
          chk("R6 busy low", int'(busy), 0);
          chk("R1 armed cleared", int'(armed), 0);
        end else chk("R3 busy", int'(busy), 1);
      end
      byte_take = 0;
    end
    tick();
    chk("R6 done one cycle", int'(done), 0);
    chk("R6 no restart", int'(busy), 0);
    chk("R7 dma idle", int'(dma_req), 0);
  endtask

  task automatic t_reset();
    chk("reset busy", int'(busy), 0);
    chk("reset remaining", int'(remaining), 0);
    chk("reset dma", int'(dma_req), 0);
    chk("reset armed", int'(armed), 0);
    chk("reset errs", int'({cfg_err, fifo_err, done}), 0);
  endtask

  task automatic t_sw_dma();
    cfg_vc = 2'd1; cfg_dma_sel = 3'd2; cfg_src_video = 0;
    load(10, 4);
    chk("R7 pre-start dma", int'(dma_req), 0);
    sw_start = 1; tick(); sw_start = 0;
    chk("R2 busy", int'(busy), 1);
    drain(10, 4, 4, 0);
  endtask

  task automatic t_auto();
    cfg_vc = 2'd3; cfg_dma_sel = 3'd0;
    load(8, 8);
    te_trig = 1; tick(); te_trig = 0;
    chk("R3 unarmed trig", int'(busy), 0);
    arm_set = 1; tick(); arm_set = 0;
    chk("R1 armed", int'(armed), 1);
    tick();
    chk("R1 waits for trig", int'(busy), 0);
    te_trig = 1; tick(); te_trig = 0;
    chk("R1 trig starts", int'(busy), 1);
    drain(8, 8, 1, 1);
    load(7, 3);
    arm_set = 1; tick(); arm_set = 0;
    te_trig = 1; tick(); te_trig = 0;
    drain(7, 3, 1, 1);
  endtask

  task automatic t_video();
    cfg_src_video = 1; cfg_linebuf = 0;
    load(3, 5);
    sw_start = 1; tick(); sw_start = 0;
    chk("R8 refused", int'(busy), 0);
    chk("R8 cfg_err", int'(cfg_err), 1);
    cfg_linebuf = 2'd1;
    sw_start = 1; tick(); sw_start = 0;
    chk("R8 start ok", int'(busy), 1);
    chk("R10 err cleared", int'(cfg_err), 0);
    drain(3, 5, 0, 0);
    cfg_src_video = 0;
  endtask

  task automatic t_fifo();
    load(4, 2);
    txfifo_nempty = 1;
    arm_set = 1; tick(); arm_set = 0;
    chk("R9 not armed", int'(armed), 0);
    chk("R9 fifo_err", int'(fifo_err), 1);
    sw_start = 1; tick(); sw_start = 0;
    chk("R9 no start", int'(busy), 0);
    txfifo_nempty = 0;
    sw_start = 1; tick(); sw_start = 0;
    chk("R9 cleared", int'(fifo_err), 0);
    drain(4, 2, 1, 0);
  endtask

  task automatic t_wc0();
    load(5, 0);
    sw_start = 1; tick(); sw_start = 0;
    chk("R10 idle", int'(busy), 0);
    chk("R10 cfg_err", int'(cfg_err), 1);
    tick();
    chk("R10 still idle", int'(busy), 0);
  endtask

  task automatic t_sel();
    cfg_dma_sel = 3'd5;
    load(2, 4);
    sw_start = 1; tick(); sw_start = 0;
    drain(2, 4, 0, 0);
    cfg_dma_sel = 3'd3;
    load(5, 2);
    sw_start = 1; tick(); sw_start = 0;
    drain(5, 2, 8, 0);
  endtask

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_sw_dma();
    t_auto();
    t_video();
    t_fifo();
    t_wc0();
    t_sel();
    finish_run();
  end
endmodule